// File: doc/BRIEF.md
# Configurable Clock Divider Cell

This cell derives one divided clock from a choice of reference sources. A dedicated primary source and a bank of secondary sources are presented to the cell as single-cycle qualifier pulses in its reference clock domain, one pulse per source period. A two-level selector picks the active source. The secondary bank entry is chosen by a select field, and a switch decides whether the primary source or the chosen bank entry is used. The selected pulse stream then drives a ratio counter. The effective ratio is set by three controls with a fixed precedence. A fixed divide-by-3 switch wins over everything else. Otherwise a divider switch either bypasses division (ratio 1) or applies a table lookup: codes 0 through 5 give ratios 1, 2, 4, 6, 8 and 12.

The divided output is given as a period marker (`outTick`, one pulse on the first source pulse of every output period) and as a level (`outLevel`). A single enable bit gates both outputs. The gate is only sampled at output period starts, so a disable or enable never cuts a high phase short. Control fields are loaded together on a write strobe. Any write that changes the effective ratio or the effective source restarts the counter, so the new ratio applies from the next source pulse. The effective source index, the effective ratio and the enable bit are read back continuously.

Top module: `clkdiv_cell`

## Requirements
- R1: With divide-by-3 switch 0 and divider switch 1, the divider-select code maps 0,1,2,3,4,5 to ratios 1,2,4,6,8,12, and codes 6 and 7 both give ratio 1; the ratio is the number of selected source pulses between successive `outTick` pulses.
- R2: With the divide-by-3 switch at 1, the ratio is 3 whatever the divider switch and divider-select code hold.
- R3: With the divide-by-3 switch at 0 and the divider switch at 0, the ratio is 1 whatever the divider-select code holds.
- R4: With the source switch at 0, only `pll0Tick` is counted; with it at 1, only `bankTick[i]` is counted, where i is the source-select code.
- R5: `rbParent` reads 0 while the source switch is 0 and reads source-select + 1 while it is 1, starting the cycle after the write.
- R6: `rbEnabled` reads the enable bit the cycle after the write; `outTick` is only ever produced when the enable bit held 1 in the cycle before, and with enable 0 no `outTick` appears and `outLevel` settles low.
- R7: The gate is applied at output period starts only: `outLevel` rises only in a cycle where `outTick` is also high.
- R8: Counted in source pulses per output period, `outLevel` is high for ratio/2 pulses at even ratios, for 1 pulse at ratio 3 (one third duty), and for every pulse at ratio 1.
- R9: A write that changes the effective ratio or the effective source restarts the counter: the first selected source pulse after the restart cycle produces `outTick`, and every following period equals the new ratio.
- R10: After reset `outTick`, `outLevel`, `rbEnabled` and `rbParent` are 0 and `rbRatio` is 1.
- R11: `rbRatio` shows the effective ratio (3, 1 or the table value, by the precedence of R1 to R3) the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| pll0Tick | input | 1 | Pulse per period of the primary source |
| bankTick | input | 2**SEL_W | Pulse per period of each secondary source |
| cfgWe | input | 1 | Loads all control fields |
| cfgPllSw | input | 1 | 0 selects primary, 1 selects a bank entry |
| cfgPllSel | input | SEL_W | Bank entry index |
| cfgDivSw | input | 1 | 0 bypasses the table divider |
| cfgDivSel | input | 3 | Table divider code |
| cfgDiv3Sw | input | 1 | 1 forces divide by 3 |
| cfgEnable | input | 1 | Output gate enable |
| outTick | output | 1 | Marks the start of each output period |
| outLevel | output | 1 | Divided clock level |
| rbParent | output | SEL_W+1 | Effective source index |
| rbEnabled | output | 1 | Enable bit readback |
| rbRatio | output | 4 | Effective division ratio |

## Verification
A counter or gate register in the wrong state appears at the ports within one output period. The interval between `outTick` pulses, counted in selected source pulses, deviates from the ratio. The count of high-level pulses inside a period deviates from the duty rule, or a first marker after a restart arrives late. Unselected sources pulse in the opposite pattern to the selected one, so a wrong selector leg changes the measured period at once. The precedence of the three ratio controls is swept exhaustively and then probed with random combinations.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CODE_W  = 3;
  localparam int RATIO_W = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic               srcTick;
    logic               restart;
    logic               gateReq;
    logic [RATIO_W-1:0] ratio;
  } dpCtl_t;

  function automatic logic [RATIO_W-1:0] tableRatio(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd1;
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      3'd5:    r = 4'd12;
      default: r = 4'd1;
    endcase
    return r;
  endfunction

  // precedence: fixed /3, then bypass, then table
  function automatic logic [RATIO_W-1:0] effRatio(input logic div3Sw, input logic divSw,
                                                  input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    if (div3Sw)      r = 4'd3;
    else if (!divSw) r = 4'd1;
    else             r = tableRatio(code);
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pll0Tick,
  input  logic [(1<<SEL_W)-1:0] bankTick,
  input  logic                  cfgWe,
  input  logic                  cfgPllSw,
  input  logic [SEL_W-1:0]      cfgPllSel,
  input  logic                  cfgDivSw,
  input  logic [CODE_W-1:0]     cfgDivSel,
  input  logic                  cfgDiv3Sw,
  input  logic                  cfgEnable,
  output dpCtl_t                ctl,
  output logic [SEL_W:0]        rbParent,
  output logic                  rbEnabled,
  output logic [RATIO_W-1:0]    rbRatio
);

  localparam int PAR_W = SEL_W + 1;

  logic              pllSwQ;
  logic [SEL_W-1:0]  pllSelQ;
  logic              divSwQ;
  logic [CODE_W-1:0] divSelQ;
  logic              div3SwQ;
  logic              enableQ;
  logic              restartQ;

  logic [RATIO_W-1:0] curRatio;
  logic [RATIO_W-1:0] newRatio;
  logic [PAR_W-1:0]   curParent;
  logic [PAR_W-1:0]   newParent;
  logic               needRestart;

  always_comb begin
    curRatio    = effRatio(div3SwQ, divSwQ, divSelQ);
    newRatio    = effRatio(cfgDiv3Sw, cfgDivSw, cfgDivSel);
    curParent   = pllSwQ    ? PAR_W'(pllSelQ) + PAR_W'(1)   : '0;
    newParent   = cfgPllSw  ? PAR_W'(cfgPllSel) + PAR_W'(1) : '0;
    needRestart = cfgWe && ((newRatio != curRatio) || (newParent != curParent));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pllSwQ   <= 1'b0;
      pllSelQ  <= '0;
      divSwQ   <= 1'b0;
      divSelQ  <= '0;
      div3SwQ  <= 1'b0;
      enableQ  <= 1'b0;
      restartQ <= 1'b0;
    end else begin
      restartQ <= needRestart;
      if (cfgWe) begin
        pllSwQ  <= cfgPllSw;
        pllSelQ <= cfgPllSel;
        divSwQ  <= cfgDivSw;
        divSelQ <= cfgDivSel;
        div3SwQ <= cfgDiv3Sw;
        enableQ <= cfgEnable;
      end
    end
  end

  always_comb begin
    ctl.srcTick = pllSwQ ? bankTick[pllSelQ] : pll0Tick;
    ctl.restart = restartQ;
    ctl.gateReq = enableQ;
    ctl.ratio   = curRatio;
  end

  assign rbParent  = curParent;
  assign rbEnabled = enableQ;
  assign rbRatio   = curRatio;

endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  output logic   outTick,
  output logic   outLevel
);

  logic [RATIO_W-1:0] phaseCnt;
  logic [RATIO_W-1:0] highLen;
  logic               gateQ;
  logic               gateNext;
  logic               periodStart;
  logic               periodEnd;
  logic               tickQ;
  logic               levelQ;

  always_comb begin
    highLen     = ((ctl.ratio >> 1) == '0) ? RATIO_W'(1) : (ctl.ratio >> 1);
    periodStart = (phaseCnt == '0);
    periodEnd   = (phaseCnt >= ctl.ratio - RATIO_W'(1));
    gateNext    = periodStart ? ctl.gateReq : gateQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      gateQ    <= 1'b0;
      tickQ    <= 1'b0;
      levelQ   <= 1'b0;
    end else if (ctl.restart) begin
      phaseCnt <= '0;
      gateQ    <= ctl.gateReq;
      tickQ    <= 1'b0;
      levelQ   <= 1'b0;
    end else if (ctl.srcTick) begin
      phaseCnt <= periodEnd ? '0 : phaseCnt + RATIO_W'(1);
      gateQ    <= gateNext;
      tickQ    <= periodStart && gateNext;
      levelQ   <= gateNext && (phaseCnt < highLen);
    end else begin
      tickQ    <= 1'b0;
    end
  end

  assign outTick  = tickQ;
  assign outLevel = levelQ;

endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pll0Tick,
  input  logic [(1<<SEL_W)-1:0] bankTick,
  input  logic                  cfgWe,
  input  logic                  cfgPllSw,
  input  logic [SEL_W-1:0]      cfgPllSel,
  input  logic                  cfgDivSw,
  input  logic [2:0]            cfgDivSel,
  input  logic                  cfgDiv3Sw,
  input  logic                  cfgEnable,
  output logic                  outTick,
  output logic                  outLevel,
  output logic [SEL_W:0]        rbParent,
  output logic                  rbEnabled,
  output logic [3:0]            rbRatio
);

  dpCtl_t ctl;

  clkdiv_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pll0Tick  (pll0Tick),
    .bankTick  (bankTick),
    .cfgWe     (cfgWe),
    .cfgPllSw  (cfgPllSw),
    .cfgPllSel (cfgPllSel),
    .cfgDivSw  (cfgDivSw),
    .cfgDivSel (cfgDivSel),
    .cfgDiv3Sw (cfgDiv3Sw),
    .cfgEnable (cfgEnable),
    .ctl       (ctl),
    .rbParent  (rbParent),
    .rbEnabled (rbEnabled),
    .rbRatio   (rbRatio)
  );

  clkdiv_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .outTick  (outTick),
    .outLevel (outLevel)
  );

endmodule

// File: rtl/clkdiv_cell_chk.sv
module clkdiv_cell_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic             cfgPllSw,
  input logic [SEL_W-1:0] cfgPllSel,
  input logic             cfgDivSw,
  input logic             cfgDiv3Sw,
  input logic             outTick,
  input logic             outLevel,
  input logic [SEL_W:0]   rbParent,
  input logic             rbEnabled,
  input logic [3:0]       rbRatio
);

  // R5: parent index follows the written switch and select
  p_parent_idx_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> rbParent == ($past(cfgPllSw) ? ({1'b0, $past(cfgPllSel)} + 1'b1) : '0));

  // R2: divide-by-3 wins over everything
  p_div3_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgDiv3Sw) |=> rbRatio == 4'd3);

  // R3: bypass gives ratio 1
  p_bypass_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgDiv3Sw && !cfgDivSw) |=> rbRatio == 4'd1);

  // R6: no period marker without the enable bit
  p_gate_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    outTick |-> $past(rbEnabled));

  // R7: the level only rises at a period start
  p_level_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outLevel) |-> outTick);

endmodule

bind clkdiv_cell clkdiv_cell_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWe     (cfgWe),
  .cfgPllSw  (cfgPllSw),
  .cfgPllSel (cfgPllSel),
  .cfgDivSw  (cfgDivSw),
  .cfgDiv3Sw (cfgDiv3Sw),
  .outTick   (outTick),
  .outLevel  (outLevel),
  .rbParent  (rbParent),
  .rbEnabled (rbEnabled),
  .rbRatio   (rbRatio)
);

// File: tb/tb_clkdiv_cell.sv
module tb_clkdiv_cell;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W      = 3;
  localparam int NBANK      = 1 << SEL_W;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pll0Tick = 1'b0;
  logic [NBANK-1:0] bankTick = '0;
  logic             cfgWe = 1'b0;
  logic             cfgPllSw = 1'b0;
  logic [SEL_W-1:0] cfgPllSel = '0;
  logic             cfgDivSw = 1'b0;
  logic [2:0]       cfgDivSel = '0;
  logic             cfgDiv3Sw = 1'b0;
  logic             cfgEnable = 1'b0;
  logic             outTick;
  logic             outLevel;
  logic [SEL_W:0]   rbParent;
  logic             rbEnabled;
  logic [3:0]       rbRatio;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  // bench model of the selected source
  bit curSw = 0;
  int curSel = 0;
  int lastRatio = 1;
  int lastParent = 0;

  clkdiv_cell #(.SEL_W(SEL_W)) dut (
    .clk(clk), .rstN(rstN), .pll0Tick(pll0Tick), .bankTick(bankTick),
    .cfgWe(cfgWe), .cfgPllSw(cfgPllSw), .cfgPllSel(cfgPllSel),
    .cfgDivSw(cfgDivSw), .cfgDivSel(cfgDivSel), .cfgDiv3Sw(cfgDiv3Sw),
    .cfgEnable(cfgEnable), .outTick(outTick), .outLevel(outLevel),
    .rbParent(rbParent), .rbEnabled(rbEnabled), .rbRatio(rbRatio)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tabRatio(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 12;
      default: return 1;
    endcase
  endfunction

  function automatic int expRatio(input bit d3, input bit sw, input int code);
    if (d3) return 3;
    if (!sw) return 1;
    return tabRatio(code);
  endfunction

  function automatic int expHigh(input int r);
    return (r / 2 == 0) ? 1 : r / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // selected source gets sel, every other source gets its complement
  task automatic driveTicks(input bit sel);
    pll0Tick = curSw ? ~sel : sel;
    for (int i = 0; i < NBANK; i++)
      bankTick[i] = (curSw && i == curSel) ? sel : ~sel;
  endtask

  task automatic driveIdle();
    pll0Tick = 1'b0;
    bankTick = '0;
  endtask

  // write a configuration, check readback, then measure two output periods
  task automatic runCfg(input bit d3, input bit sw, input int code,
                        input bit psw, input int psel, input bit en, input string tag);
    int r;
    int par;
    bit restartExp;
    int tickCount;
    int prevMark;
    int marks;
    int highCnt;
    bit lastDrive;
    bit sel;
    r   = expRatio(d3, sw, code);
    par = psw ? psel + 1 : 0;
    restartExp = (r != lastRatio) || (par != lastParent);
    @(negedge clk);
    driveIdle();
    cfgWe = 1'b1; cfgDiv3Sw = d3; cfgDivSw = sw; cfgDivSel = 3'(code);
    cfgPllSw = psw; cfgPllSel = SEL_W'(psel); cfgEnable = en;
    @(negedge clk);
    cfgWe = 1'b0;
    curSw = psw; curSel = psel;
    chk({tag, " R11 rbRatio"}, int'(rbRatio), r);
    chk("R5 rbParent", int'(rbParent), par);
    chk("R6 rbEnabled", int'(rbEnabled), int'(en));
    lastRatio = r; lastParent = par;
    @(negedge clk);
    tickCount = 0; prevMark = 0; marks = 0; highCnt = 0; lastDrive = 0;
    for (int it = 0; it < 3000 && marks < 3; it++) begin
      @(negedge clk);
      if (lastDrive && outTick) begin
        if (marks == 0 && restartExp)
          chk("R9 first marker after restart", tickCount, 1);
        if (marks > 0) begin
          chk({tag, " R4 period"}, tickCount - prevMark, r);
          chk("R8 high pulses per period", highCnt, expHigh(r));
        end
        prevMark = tickCount;
        marks++;
        highCnt = 0;
      end
      if (lastDrive && outLevel) highCnt++;
      sel = 1'($urandom_range(0, 1));
      driveTicks(sel);
      if (sel) tickCount++;
      lastDrive = sel;
    end
    chk("R9 markers seen", marks, 3);
    @(negedge clk);
    driveIdle();
  endtask

  // disable the gate and watch that nothing passes
  task automatic runOff(input string tag);
    int seen;
    @(negedge clk);
    driveIdle();
    cfgWe = 1'b1; cfgEnable = 1'b0;
    @(negedge clk);
    cfgWe = 1'b0;
    chk("R6 rbEnabled off", int'(rbEnabled), 0);
    seen = 0;
    for (int it = 0; it < 120; it++) begin
      driveTicks(1'($urandom_range(0, 1)));
      @(negedge clk);
      if (outTick) seen++;
    end
    chk({tag, " R6 markers while off"}, seen, 0);
    chk({tag, " R6 level while off"}, int'(outLevel), 0);
    driveIdle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h1d5e_ed01);
    repeat (3) @(negedge clk);
    // R10: state during and right after reset
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 outTick", int'(outTick), 0);
    chk("R10 outLevel", int'(outLevel), 0);
    chk("R10 rbParent", int'(rbParent), 0);
    chk("R10 rbEnabled", int'(rbEnabled), 0);
    chk("R10 rbRatio", int'(rbRatio), 1);

    // exhaustive sweep of precedence: R1, R2, R3, with varying sources (R4)
    for (int d3 = 0; d3 < 2; d3++)
      for (int sw = 0; sw < 2; sw++)
        for (int code = 0; code < 8; code++) begin
          bit psw;
          int psel;
          psw  = 1'($urandom_range(0, 1));
          psel = $urandom_range(0, NBANK - 1);
          if (d3 == 1)      runCfg(1'(d3), 1'(sw), code, psw, psel, 1'b1, "R2");
          else if (sw == 0) runCfg(1'(d3), 1'(sw), code, psw, psel, 1'b1, "R3");
          else              runCfg(1'(d3), 1'(sw), code, psw, psel, 1'b1, "R1");
        end

    // every bank entry and the primary source, at ratio 6
    runCfg(1'b0, 1'b1, 3, 1'b0, 5, 1'b1, "R4 primary");
    for (int s = 0; s < NBANK; s++)
      runCfg(1'b0, 1'b1, 3, 1'b1, s, 1'b1, "R4 bank");

    // gate off and back on without a ratio change
    runCfg(1'b0, 1'b1, 5, 1'b1, 2, 1'b1, "R1");
    runOff("R6");
    runCfg(1'b0, 1'b1, 5, 1'b1, 2, 1'b1, "R6 reenable");
    runCfg(1'b0, 1'b0, 0, 1'b0, 0, 1'b1, "R3");
    runOff("R6 ratio1");

    // random mix
    for (int n = 0; n < 24; n++)
      runCfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 7),
             1'($urandom_range(0, 1)), $urandom_range(0, NBANK - 1), 1'b1, "R1 random");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule